// File: doc/BRIEF.md
# TDM Time-Slot Serial Transmitter

This block sends audio samples one bit per bit clock into a programmable slot of a framed serial bus. Four serial lines are available, each with its own frame sync and bit clock; a two-bit selector chooses the line that times the slot and that the block drives. The bit clocks and frame syncs arrive as level signals. The block samples them on its own system clock and turns each rising edge of the selected bit clock into a bit event. A bit counter restarts at every frame sync. The block drives data only while that counter lies inside the slot window; outside the window the output enable stays low, so the line is left in high impedance.

Sample data reaches the block through a 32-bit write register. Writes to it come from one of two sources, the DSP or the host, and a configuration bit picks which of the two is accepted. The shift register refills under one of two policies. In per-frame mode it reloads at every frame sync. In on-demand mode it reloads once a programmable multiple of the slot length has been sent, and at that point it raises a sticky buffer-empty status so that software can refill the write register. When that multiple times the slot length would exceed the register width, the configuration is illegal: the block flags it and clamps the reload size to 32 bits. All configuration must be held steady while the enable is low.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, ser_data, ser_oe, bemp and the internal write register are zero, and the bit counter is parked so that no slot is reached before the first frame sync.
- R2: While cfg_en is 0, ser_oe is all zeros from the next clock on, bemp is never set, and bit-clock edges have no effect.
- R3: cfg_line (00, 01, 10, 11) selects line index 0 to 3: only that line's bit clock and frame sync time the channel, and the enable raised is ser_oe bit cfg_line, never any other bit.
- R4: A rising edge of the selected bit clock taken with its frame sync high is bit index 0; every later rising edge adds one to the index, which saturates at 1023.
- R5: Data is driven (ser_oe set) for exactly the bit indices cfg_pos to cfg_pos+cfg_len, that is cfg_len+1 bits per frame.
- R6: The sample is the low bits of the write register, sent most significant bit first. ser_data is 0 whenever the line is not driven.
- R7: With cfg_lmode=0, each frame-sync edge copies the low cfg_len+1 bits of the write register into the shift register, and these bits are sent in that frame's slot, including a slot that starts at index 0.
- R8: With cfg_lmode=1, the shift register holds (cfg_lmult+1)*(cfg_len+1) bits taken from the low end of the write register. It reloads on the edge that sends the last of those bits, and the same edge sets bemp.
- R9: When (cfg_lmult+1)*(cfg_len+1) exceeds 32, cfg_bad is 1 and the on-demand reload size is clamped to 32 bits. Otherwise cfg_bad is 0.
- R10: bemp stays set until an accepted write clears it. A write is accepted from dsp_wr when cfg_src=0 and from host_wr when cfg_src=1; a write from the other source is ignored. A write in the same cycle as a set leaves bemp clear.
- R11: ser_data and ser_oe change only on the clock that sees a selected bit-clock rising edge, or when the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_line | input | 2 | Line select, 0 to 3 |
| cfg_len | input | 5 | Slot length minus one |
| cfg_pos | input | 9 | Bit index of the slot's first bit |
| cfg_lmode | input | 1 | 0 = reload per frame, 1 = reload on demand |
| cfg_lmult | input | 5 | On-demand reload size in slot lengths, minus one |
| cfg_src | input | 1 | Accepted write source: 0 DSP, 1 host |
| line_fsync | input | 4 | Frame sync level for each line |
| line_bclk | input | 4 | Bit clock level for each line |
| dsp_wr | input | 1 | Write strobe from the DSP |
| host_wr | input | 1 | Write strobe from the host |
| wr_data | input | 32 | Write data |
| ser_data | output | 1 | Serial data bit |
| ser_oe | output | 4 | Output enable for each line, at most one set |
| bemp | output | 1 | Sticky buffer-empty status |
| cfg_bad | output | 1 | Reload-size product exceeds 32 |

## Verification
A wrong bit counter or slot decode shows up as ser_oe rising or falling at the wrong bit clock, visible one system clock after that bit clock's edge. Errors in the shift register or in reload timing show up as a wrong ser_data bit within the same slot. A wrong on-demand count also moves the edge on which bemp rises. Because the bench's reference model is compared on every clock, each of these errors is caught at the first bit clock where the ports differ, and so are output changes between bit-clock edges and enables on unselected lines.

// File: rtl/tdm_tx_pkg.sv
// Package: shared sizes and helpers for the TDM slot transmitter.
// Assumes a data register of at most 32 bits and a 10-bit bit counter.
package tdm_tx_pkg;
    parameter int TDM_DW    = 32;  // write/shift register width
    parameter int TDM_LINES = 4;   // selectable serial lines
    parameter int TDM_LENW  = 5;   // slot length field width
    parameter int TDM_POSW  = 9;   // slot position field width
    parameter int TDM_CNTW  = 10;  // bit counter width

    // Width needed to hold a bit count 0..dw inclusive.
    function automatic int cnt_bits(input int dw);
        return $clog2(dw) + 1;
    endfunction
endpackage

// File: rtl/tdm_line_sel.sv
// Line selector: samples every line's bit clock and picks the selected line's
// rising edge (bit_tick) and the frame sync seen on that edge (frame_tick).
// Assumes the bit clocks are much slower than clk, so each level lasts at least one clk.
module tdm_line_sel #(
    parameter int LINES = 4,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [LINES-1:0] line_fsync,
    input  logic [LINES-1:0] line_bclk,
    output logic             bit_tick,
    output logic             frame_tick
);
    logic [LINES-1:0] bclk_q;

    // Keep the previous level of every line so that a line switch sees a clean edge.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= '0;
        else        bclk_q <= line_bclk;
    end

    // Rising edge of the selected bit clock; frame sync is taken on that edge.
    always_comb begin
        bit_tick   = line_bclk[sel] & ~bclk_q[sel];
        frame_tick = bit_tick & line_fsync[sel];
    end

    // An edge event cannot repeat on the next clock unless the line changed (R3).
    assert_single_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (!bit_tick || sel != $past(sel)));
endmodule

// File: rtl/tdm_slot_timer.sv
// Slot timer: bit counter restarted by frame sync and the in-slot decode.
// Assumes pos+len never reaches the saturation value, so a parked counter is outside every slot.
module tdm_slot_timer #(
    parameter int CNTW = 10,
    parameter int LENW = 5,
    parameter int POSW = 9,
    localparam logic [CNTW-1:0] CNT_MAX = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            bit_tick,
    input  logic            frame_tick,
    input  logic [POSW-1:0] pos,
    input  logic [LENW-1:0] len,
    output logic            in_slot
);
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] idx;
    logic [CNTW-1:0] slot_lo;
    logic [CNTW-1:0] slot_hi;

    // Index of the bit on the current edge: zero on frame sync, else previous plus one, saturating.
    always_comb begin
        if (frame_tick)            idx = '0;
        else if (cnt_q == CNT_MAX) idx = CNT_MAX;
        else                       idx = cnt_q + 1'b1;
        slot_lo = CNTW'(pos);
        slot_hi = CNTW'(pos) + CNTW'(len);
        in_slot = bit_tick && (idx >= slot_lo) && (idx <= slot_hi);
    end

    // Hold the index of the last bit; park at the top while disabled or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= CNT_MAX;
        else if (!en)      cnt_q <= CNT_MAX;
        else if (bit_tick) cnt_q <= idx;
    end

    // A frame-sync edge restarts the count at zero (R4).
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && frame_tick) |=> (cnt_q == '0));
    // The count only moves on a bit edge while enabled (R4).
    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/tdm_shift_core.sv
// Shift core: the shift register, both reload policies, the reload-size clamp,
// the serial output register and the sticky buffer-empty status.
// Assumes that configuration only changes while en is low.
module tdm_shift_core #(
    parameter int DW   = 32,
    parameter int LENW = 5,
    localparam int CW  = tdm_tx_pkg::cnt_bits(DW),
    localparam int PW  = 2 * LENW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            bit_tick,
    input  logic            frame_tick,
    input  logic            in_slot,
    input  logic            lmode,
    input  logic [LENW-1:0] len,
    input  logic [LENW-1:0] lmult,
    input  logic [DW-1:0]   wreg,
    input  logic            wr_accept,
    output logic            ser_bit,
    output logic            ser_act,
    output logic            bemp,
    output logic            cfg_bad
);
    logic [PW-1:0]   prod;
    logic [CW-1:0]   tot;
    logic [DW-1:0]   aligned;
    logic [DW-1:0]   src;
    logic [DW-1:0]   sh_q,   sh_d;
    logic [CW-1:0]   sent_q, sent_d;
    logic            bit_q,  bit_d;
    logic            act_q,  act_d;
    logic            bemp_q, bemp_d;
    logic            set_empty;

    // Reload size: slot length per frame, or the clamped multiple in on-demand mode.
    always_comb begin
        prod    = (PW'(lmult) + 1'b1) * (PW'(len) + 1'b1);
        cfg_bad = (prod > PW'(DW));
        if (!lmode)       tot = CW'(len) + 1'b1;
        else if (cfg_bad) tot = CW'(DW);
        else              tot = prod[CW-1:0];
        aligned = wreg << (CW'(DW) - tot);
    end

    // Next state of the shift path: preload while idle, per-frame load, shift or on-demand reload.
    always_comb begin
        src       = (frame_tick && !lmode) ? aligned : sh_q;
        sh_d      = sh_q;
        sent_d    = sent_q;
        bit_d     = bit_q;
        act_d     = act_q;
        set_empty = 1'b0;
        if (!en) begin
            sh_d   = aligned;
            sent_d = '0;
            bit_d  = 1'b0;
            act_d  = 1'b0;
        end else if (bit_tick) begin
            sh_d  = src;
            act_d = in_slot;
            bit_d = in_slot ? src[DW-1] : 1'b0;
            if (in_slot) begin
                if (lmode && (sent_q + 1'b1 == tot)) begin
                    sh_d      = aligned;
                    sent_d    = '0;
                    set_empty = 1'b1;
                end else begin
                    sh_d   = src << 1;
                    sent_d = sent_q + 1'b1;
                end
            end
        end
    end

    // Sticky empty flag: an accepted write clears it and wins over a set.
    always_comb begin
        if (wr_accept)      bemp_d = 1'b0;
        else if (set_empty) bemp_d = 1'b1;
        else                bemp_d = bemp_q;
    end

    // Register the shift path and the status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sent_q <= '0;
            bit_q  <= 1'b0;
            act_q  <= 1'b0;
            bemp_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            sent_q <= sent_d;
            bit_q  <= bit_d;
            act_q  <= act_d;
            bemp_q <= bemp_d;
        end
    end

    assign ser_bit = bit_q;
    assign ser_act = act_q;
    assign bemp    = bemp_q;

    // Outputs hold between bit edges while enabled (R11).
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_tick) |=> ($stable(bit_q) && $stable(act_q)));
    // Data is zero whenever the line is not driven (R6).
    assert_quiet_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> !bit_q);
    // An accepted write leaves the flag clear (R10).
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !bemp_q);
    // The reload count never passes the reload size in on-demand mode (R8).
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lmode) |=> (sent_q < $past(tot)));
    // An illegal product clamps the on-demand size to the full register (R9).
    always_comb begin
        if (rst_n && lmode && cfg_bad)
            assert_clamp_R9: assert (tot == CW'(DW));
    end
endmodule

// File: rtl/tdm_slot_tx.sv
// Top: TDM time-slot serial transmitter. Holds the write register, picks the
// accepted write source, and decodes the output enable onto the selected line.
// Assumes configuration is changed only with cfg_en low.
module tdm_slot_tx #(
    parameter int DW    = tdm_tx_pkg::TDM_DW,
    parameter int LINES = tdm_tx_pkg::TDM_LINES,
    parameter int LENW  = tdm_tx_pkg::TDM_LENW,
    parameter int POSW  = tdm_tx_pkg::TDM_POSW,
    parameter int CNTW  = tdm_tx_pkg::TDM_CNTW,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [SEL_W-1:0] cfg_line,
    input  logic [LENW-1:0]  cfg_len,
    input  logic [POSW-1:0]  cfg_pos,
    input  logic             cfg_lmode,
    input  logic [LENW-1:0]  cfg_lmult,
    input  logic             cfg_src,
    input  logic [LINES-1:0] line_fsync,
    input  logic [LINES-1:0] line_bclk,
    input  logic             dsp_wr,
    input  logic             host_wr,
    input  logic [DW-1:0]    wr_data,
    output logic             ser_data,
    output logic [LINES-1:0] ser_oe,
    output logic             bemp,
    output logic             cfg_bad
);
    logic          bit_tick;
    logic          frame_tick;
    logic          in_slot;
    logic          wr_accept;
    logic [DW-1:0] wreg_q;
    logic          ser_act;

    // Only the source named by cfg_src may write.
    assign wr_accept = cfg_src ? host_wr : dsp_wr;

    // Write register, loaded by the accepted source.
    always_ff @(posedge clk) begin
        if (!rst_n)         wreg_q <= '0;
        else if (wr_accept) wreg_q <= wr_data;
    end

    tdm_line_sel #(.LINES(LINES)) u_sel (
        .clk(clk), .rst_n(rst_n), .sel(cfg_line),
        .line_fsync(line_fsync), .line_bclk(line_bclk),
        .bit_tick(bit_tick), .frame_tick(frame_tick)
    );

    tdm_slot_timer #(.CNTW(CNTW), .LENW(LENW), .POSW(POSW)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(cfg_en),
        .bit_tick(bit_tick), .frame_tick(frame_tick),
        .pos(cfg_pos), .len(cfg_len), .in_slot(in_slot)
    );

    tdm_shift_core #(.DW(DW), .LENW(LENW)) u_core (
        .clk(clk), .rst_n(rst_n), .en(cfg_en),
        .bit_tick(bit_tick), .frame_tick(frame_tick), .in_slot(in_slot),
        .lmode(cfg_lmode), .len(cfg_len), .lmult(cfg_lmult),
        .wreg(wreg_q), .wr_accept(wr_accept),
        .ser_bit(ser_data), .ser_act(ser_act), .bemp(bemp), .cfg_bad(cfg_bad)
    );

    // One enable per line; only the selected line is driven.
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_oe
            assign ser_oe[g] = ser_act && (cfg_line == SEL_W'(g));
        end
    endgenerate

    // At most one line is driven (R3).
    assert_oe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ser_oe));
    // Disabled channel drives nothing on the next clock (R2).
    assert_off_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (ser_oe == '0));
    // A disabled channel never raises the empty status (R2).
    assert_no_empty_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !bemp) |=> !bemp);
endmodule

// File: tb/tdm_slot_tx_bench.sv
`timescale 1ns/1ps
module tdm_slot_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_line = 2'd0;
    logic [4:0]  cfg_len = 5'd0;
    logic [8:0]  cfg_pos = 9'd0;
    logic        cfg_lmode = 1'b0;
    logic [4:0]  cfg_lmult = 5'd0;
    logic        cfg_src = 1'b0;
    logic [3:0]  line_fsync = 4'd0;
    logic [3:0]  line_bclk = 4'd0;
    logic        dsp_wr = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic        ser_data;
    logic [3:0]  ser_oe;
    logic        bemp;
    logic        cfg_bad;

    always #4 clk = ~clk;  // 125 MHz

    tdm_slot_tx u_tdm_slot_tx (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_line(cfg_line),
        .cfg_len(cfg_len), .cfg_pos(cfg_pos), .cfg_lmode(cfg_lmode),
        .cfg_lmult(cfg_lmult), .cfg_src(cfg_src), .line_fsync(line_fsync),
        .line_bclk(line_bclk), .dsp_wr(dsp_wr), .host_wr(host_wr),
        .wr_data(wr_data), .ser_data(ser_data), .ser_oe(ser_oe),
        .bemp(bemp), .cfg_bad(cfg_bad)
    );

    int    vectors = 0;
    int    fails = 0;
    string tag = "R1";
    bit    noise = 1'b0;
    bit    done = 1'b0;

    // Reference model state.
    bit [3:0]  m_prev;
    int        m_cnt;
    bit [31:0] m_wreg;
    bit        m_q[$];
    bit        m_bit, m_act, m_bemp;

    function automatic int total_bits();
        int p;
        if (!cfg_lmode) return cfg_len + 1;
        p = (cfg_lmult + 1) * (cfg_len + 1);
        return (p > 32) ? 32 : p;
    endfunction

    function automatic void load(input int n);
        m_q.delete();
        for (int i = n - 1; i >= 0; i--) m_q.push_back(m_wreg[i]);
    endfunction

    // Advance the model by one clock using the inputs now applied.
    function automatic void model_step();
        bit rise, fs, acc, setb, insl;
        int idx;
        if (!rst_n) begin
            m_prev = '0; m_cnt = 1023; m_wreg = '0;
            m_bit = 0; m_act = 0; m_bemp = 0;
            load(total_bits());
            return;
        end
        rise = line_bclk[cfg_line] && !m_prev[cfg_line];
        fs   = line_fsync[cfg_line];
        acc  = cfg_src ? host_wr : dsp_wr;
        setb = 0;
        if (!cfg_en) begin
            m_cnt = 1023; load(total_bits()); m_bit = 0; m_act = 0;
        end else if (rise) begin
            idx = fs ? 0 : ((m_cnt < 1023) ? m_cnt + 1 : 1023);
            m_cnt = idx;
            if (fs && !cfg_lmode) load(cfg_len + 1);
            insl = (idx >= cfg_pos) && (idx <= cfg_pos + cfg_len);
            m_act = insl; m_bit = 0;
            if (insl) begin
                m_bit = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
                if (cfg_lmode && m_q.size() == 0) begin
                    load(total_bits()); setb = 1;
                end
            end
        end
        if (acc) m_bemp = 0; else if (setb) m_bemp = 1;
        if (acc) m_wreg = wr_data;
        m_prev = line_bclk;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s phase=%s actual=%0h expected=%0h", req, what, tag, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic compare();
        bit [3:0] exp_oe;
        int p;
        vectors++;
        exp_oe = m_act ? (4'b1 << cfg_line) : 4'b0;
        p = (cfg_lmult + 1) * (cfg_len + 1);
        chk("R6", "ser_data", ser_data, m_bit);
        chk("R5", "ser_oe", ser_oe, exp_oe);
        chk("R8", "bemp", bemp, m_bemp);
        chk("R9", "cfg_bad", cfg_bad, (p > 32) ? 1 : 0);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    // One bit period on the selected line: high phase then low phase.
    task automatic bitp(input bit fs);
        line_bclk = '0; line_fsync = '0;
        line_bclk[cfg_line] = 1'b1;
        line_fsync[cfg_line] = fs;
        tick();
        dsp_wr = 0; host_wr = 0;
        line_bclk = noise ? ~(4'b1 << cfg_line) : 4'b0;
        line_fsync = noise ? ~(4'b1 << cfg_line) : 4'b0;
        tick();
    endtask

    task automatic frame(input int nbits);
        for (int b = 0; b < nbits; b++) bitp(b == 0);
    endtask

    task automatic setup(input bit [1:0] ln, input int len, input int pos,
                         input bit lm, input int mult, input bit src);
        cfg_en = 0; line_bclk = '0; line_fsync = '0;
        tick();
        cfg_line = ln; cfg_len = 5'(len); cfg_pos = 9'(pos);
        cfg_lmode = lm; cfg_lmult = 5'(mult); cfg_src = src;
        tick();
    endtask

    task automatic wr(input bit from_host, input bit [31:0] d);
        wr_data = d; dsp_wr = !from_host; host_wr = from_host;
        tick();
        dsp_wr = 0; host_wr = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired phase=%s", tag);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        tag = "R1";
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1;
        tick();
        // R1: a frame after reset but before any write sends zeros (write register cleared).
        setup(0, 3, 0, 0, 0, 0);
        cfg_en = 1;
        frame(6);

        // R7 / R6: per-frame load on line 0, slot at bits 3..10.
        tag = "R7";
        setup(0, 7, 3, 0, 0, 0);
        wr(0, 32'h0000_12A5);
        cfg_en = 1;
        frame(16);
        wr(0, 32'h0000_003C);
        frame(16);
        // R7: slot at index 0 uses the freshly loaded word.
        setup(0, 3, 0, 0, 0, 0);
        wr(0, 32'h0000_0009);
        cfg_en = 1;
        frame(8);
        frame(8);

        // R2: disabled channel ignores bit clocks.
        tag = "R2";
        cfg_en = 0;
        frame(10);

        // R3: line 2 selected, the other lines toggle.
        tag = "R3";
        setup(2, 4, 0, 0, 0, 0);
        wr(0, 32'h0000_0016);
        noise = 1;
        cfg_en = 1;
        frame(10);
        frame(10);
        noise = 0;

        // R11: idle clocks and writes between bit edges.
        tag = "R11";
        bitp(1);
        for (int i = 0; i < 6; i++) begin
            line_bclk = '0;
            wr(0, 32'h0000_00F0 + i);
        end
        for (int b = 0; b < 8; b++) bitp(0);

        // R4: frame sync arriving early restarts the count.
        tag = "R4";
        setup(1, 1, 3, 0, 0, 0);
        wr(0, 32'h0000_0002);
        cfg_en = 1;
        frame(2);
        frame(7);
        frame(7);

        // R5: wide slot at a later position.
        tag = "R5";
        setup(3, 31, 40, 0, 0, 0);
        wr(0, 32'hC0FF_EE17);
        cfg_en = 1;
        frame(80);

        // R8: on-demand mode, 8-bit reload size over 4-bit slots, host source.
        tag = "R8";
        setup(3, 3, 2, 1, 1, 1);
        wr(1, 32'h0000_00B6);
        cfg_en = 1;
        wr(1, 32'h0000_005A);
        frame(8);
        frame(8);

        // R10: write from the other source is ignored, then the selected one clears.
        tag = "R10";
        wr(0, 32'h0000_0011);
        tick();
        wr(1, 32'h0000_0077);
        frame(8);
        // Same-cycle write and set: write wins.
        for (int b = 0; b < 8; b++) begin
            if (b == 5) begin wr_data = 32'h0000_0033; host_wr = 1; end
            bitp(b == 0);
        end
        frame(8);

        // R9: illegal product, clamped to 32 bits.
        tag = "R9";
        setup(0, 7, 0, 1, 7, 0);
        wr(0, 32'h8765_4321);
        cfg_en = 1;
        frame(40);
        frame(40);
        cfg_en = 0;
        tick();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule